// File: doc/BRIEF.md
# Dual-Function PCI Target Address Decoder

This block watches a 32-bit multiplexed PCI address/data bus and, in the address phase of each transaction, decides whether one of two independent functions behind a shared bus interface is being addressed. The command nibble sampled with the address classifies the cycle as configuration, I/O or memory space, and as a read or a write. Configuration cycles are claimed through the chip-select input and a function-number field. I/O and memory cycles are claimed by comparing the upper address bits against base values that each function holds per space.

The decode is captured in a register on the clock edge that starts a transaction. It stays constant through the data phases and is cleared once the bus returns to idle. Downstream logic receives a hit flag, the space, the function index, the direction, a byte register offset and a flag that marks a base overlap between the two functions.

Top module: `pci_dual_target_decode`

## Requirements
- R1: While reset is low, and after reset until the first address phase, all decode outputs are zero.
- R2: A configuration command (4'b1010 read, 4'b1011 write) with `idsel_i` high and AD[10:8] = 3'b000 or 3'b001 is claimed. `space_o` is 2'd1, `func_o` equals AD[8] (0 = function A, 1 = function B), and `offset_o` equals AD[7:0].
- R3: A configuration command is not claimed when `idsel_i` is low, or when AD[10:8] is in the range 2 to 7.
- R4: An I/O command (4'b0010 read, 4'b0011 write) hits a function whose I/O space is enabled and whose 24-bit I/O base equals AD[31:8]. `space_o` is 2'd2 and `offset_o` equals AD[7:0].
- R5: A memory command (4'b0110 read, 4'b0111 write) hits a function whose memory space is enabled and whose 24-bit memory base equals AD[31:8]. `space_o` is 2'd3 and `offset_o` equals AD[7:0].
- R6: A space whose enable input is low never produces a hit, even when its base matches.
- R7: Every command value other than the six listed above produces no hit: `hit_o` is 0 and all other outputs are 0.
- R8: On a hit, `write_o` is 1 for the three write commands and 0 for the three read commands.
- R9: When both functions match the same I/O or memory address, function A (`func_o` = 0) is selected and `overlap_o` is 1. Otherwise `overlap_o` is 0.
- R10: The decode is registered on the rising clock edge where `frame_n_i` is sampled low after having been sampled high on the edge before. It is held until an edge where `frame_n_i` and `irdy_n_i` are both sampled high, and on that edge all outputs return to zero.
- R11: Changes on `ad_i`, `cmd_i` and `idsel_i` during the data phases of a transaction do not alter the held decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n_i | input | 1 | Transaction frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration chip select |
| ad_i | input | 32 | Multiplexed address/data bus |
| cmd_i | input | 4 | Command / byte-enable lines |
| io_base_i | input | 2x24 | Per-function I/O base, index 0 = function A |
| io_en_i | input | 2 | Per-function I/O space enable |
| mem_base_i | input | 2x24 | Per-function memory base, index 0 = function A |
| mem_en_i | input | 2 | Per-function memory space enable |
| hit_o | output | 1 | Transaction claimed by one of the functions |
| space_o | output | 2 | 0 none, 1 configuration, 2 I/O, 3 memory |
| func_o | output | 1 | Claiming function, 0 = A, 1 = B |
| write_o | output | 1 | Claimed cycle is a write |
| offset_o | output | 8 | Byte register offset |
| overlap_o | output | 1 | Both functions matched the address |

## Verification
The only state is the previous frame level and the held decode, so any corruption appears at the ports. A wrong edge detector either captures a data-phase address, which shows one clock into the transaction as a changed offset or function, or misses the start of a transaction, which shows on the first sample after the address edge as a missing hit. A wrong clearing condition leaves a stale hit visible on the first idle clock after FRAME# and IRDY# both rise. Wrong base, enable or priority logic shows one clock after the address edge as a wrong hit, function or overlap value.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_CFG  = 2'd1,
        SP_IO   = 2'd2,
        SP_MEM  = 2'd3
    } space_e;

    typedef struct packed {
        logic       hit;
        space_e     space;
        logic       func;
        logic       wr;
        logic [7:0] off;
        logic       ovl;
    } dec_t;

endpackage

// File: rtl/pci_cmd_decode.sv
module pci_cmd_decode (
    input  logic [3:0] cmd_i,
    output logic       is_cfg_o,
    output logic       is_io_o,
    output logic       is_mem_o,
    output logic       is_wr_o
);
    always_comb begin
        is_cfg_o = 1'b0;
        is_io_o  = 1'b0;
        is_mem_o = 1'b0;
        is_wr_o  = cmd_i[0];
        case (cmd_i)
            4'b1010, 4'b1011: is_cfg_o = 1'b1;
            4'b0010, 4'b0011: is_io_o  = 1'b1;
            4'b0110, 4'b0111: is_mem_o = 1'b1;
            default:          is_wr_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/pci_bar_match.sv
module pci_bar_match #(
    parameter int AW = 32,
    parameter int OW = 8,
    localparam int BW = AW - OW
) (
    input  logic [AW-1:0] ad_i,
    input  logic [BW-1:0] base_i,
    input  logic          en_i,
    output logic          match_o
);
    always_comb begin
        match_o = en_i && (ad_i[AW-1:OW] == base_i);
    end
endmodule

// File: rtl/pci_dual_target_decode.sv
module pci_dual_target_decode
    import pci_dec_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 8,
    localparam int BW = AW - OW,
    localparam int NF = 2,
    localparam int FN_LSB = OW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_n_i,
    input  logic               irdy_n_i,
    input  logic               idsel_i,
    input  logic [AW-1:0]      ad_i,
    input  logic [3:0]         cmd_i,
    input  logic [NF-1:0][BW-1:0] io_base_i,
    input  logic [NF-1:0]      io_en_i,
    input  logic [NF-1:0][BW-1:0] mem_base_i,
    input  logic [NF-1:0]      mem_en_i,
    output logic               hit_o,
    output logic [1:0]         space_o,
    output logic               func_o,
    output logic               write_o,
    output logic [7:0]         offset_o,
    output logic               overlap_o
);

    typedef struct packed {
        logic frame_prev;
        dec_t res;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec_new;
    logic   is_cfg, is_io, is_mem, is_wr;
    logic   addr_phase;
    logic [NF-1:0] io_m, mem_m, sel_m;

    pci_cmd_decode u_cmd (
        .cmd_i    (cmd_i),
        .is_cfg_o (is_cfg),
        .is_io_o  (is_io),
        .is_mem_o (is_mem),
        .is_wr_o  (is_wr)
    );

    for (genvar f = 0; f < NF; f++) begin : g_fn
        pci_bar_match #(.AW(AW), .OW(OW)) u_io (
            .ad_i    (ad_i),
            .base_i  (io_base_i[f]),
            .en_i    (io_en_i[f]),
            .match_o (io_m[f])
        );
        pci_bar_match #(.AW(AW), .OW(OW)) u_mem (
            .ad_i    (ad_i),
            .base_i  (mem_base_i[f]),
            .en_i    (mem_en_i[f]),
            .match_o (mem_m[f])
        );
    end

    always_comb begin
        addr_phase = !frame_n_i && st_q.frame_prev;
        sel_m      = is_io ? io_m : (is_mem ? mem_m : '0);
        dec_new    = '0;
        if (is_cfg) begin
            if (idsel_i && (ad_i[FN_LSB+2:FN_LSB+1] == 2'b00)) begin
                dec_new.hit   = 1'b1;
                dec_new.space = SP_CFG;
                dec_new.func  = ad_i[FN_LSB];
            end
        end else if (|sel_m) begin
            dec_new.hit   = 1'b1;
            dec_new.space = is_io ? SP_IO : SP_MEM;
            dec_new.func  = !sel_m[0];
            dec_new.ovl   = &sel_m;
        end
        if (dec_new.hit) begin
            dec_new.wr  = is_wr;
            dec_new.off = ad_i[7:0];
        end

        st_d            = st_q;
        st_d.frame_prev = frame_n_i;
        if (addr_phase) begin
            st_d.res = dec_new;
        end else if (frame_n_i && irdy_n_i) begin
            st_d.res = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.frame_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o     = st_q.res.hit;
    assign space_o   = st_q.res.space;
    assign func_o    = st_q.res.func;
    assign write_o   = st_q.res.wr;
    assign offset_o  = st_q.res.off;
    assign overlap_o = st_q.res.ovl;

    // R3: configuration without chip select is never claimed
    a_r3_no_idsel_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && is_cfg && !idsel_i) |=> !hit_o);

    // R7: unlisted commands are never claimed
    a_r7_unknown_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && !is_cfg && !is_io && !is_mem) |=> !hit_o);

    // R9: overlap only with a hit and function A selected
    a_r9_overlap_prio: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_o |-> (hit_o && !func_o));

    // R10: decode is held through the data phases
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.frame_prev && !(frame_n_i && irdy_n_i)) |=> $stable(st_q.res));

    // R10: bus idle clears the decode
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n_i && irdy_n_i) |=> (!hit_o && !overlap_o));

endmodule

// File: tb/sim_pci_dual_target_decode.sv
module sim_pci_dual_target_decode;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0] cmd = '0;
    logic [1:0][23:0] io_b, mem_b;
    logic [1:0] io_en, mem_en;
    logic hit, func, wr, ovl;
    logic [1:0] space;
    logic [7:0] off;
    int checks = 0, errors = 0;
    bit done = 0;

    pci_dual_target_decode u0 (
        .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
        .idsel_i(idsel), .ad_i(ad), .cmd_i(cmd),
        .io_base_i(io_b), .io_en_i(io_en), .mem_base_i(mem_b), .mem_en_i(mem_en),
        .hit_o(hit), .space_o(space), .func_o(func), .write_o(wr),
        .offset_o(off), .overlap_o(ovl)
    );

    always #10 clk = ~clk;

    function automatic logic [13:0] model(logic [3:0] c, logic [31:0] a, logic ids);
        logic [13:0] r;
        logic io, mem, m0, m1;
        r   = '0;
        io  = (c[3:1] == 3'b001);
        mem = (c[3:1] == 3'b011);
        if (c[3:1] == 3'b101) begin
            if (ids && a[10:9] == 2'b00) r = {1'b1, 2'd1, a[8], c[0], a[7:0], 1'b0};
        end else if (io || mem) begin
            m0 = io ? (io_en[0] && a[31:8] == io_b[0]) : (mem_en[0] && a[31:8] == mem_b[0]);
            m1 = io ? (io_en[1] && a[31:8] == io_b[1]) : (mem_en[1] && a[31:8] == mem_b[1]);
            if (m0 || m1) r = {1'b1, io ? 2'd2 : 2'd3, !m0, c[0], a[7:0], m0 && m1};
        end
        return r;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(string tag, logic [13:0] exp);
        logic [13:0] got;
        got = {hit, space, func, wr, off, ovl};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic txn(logic [3:0] c, logic [31:0] a, logic ids, string tag);
        logic [13:0] e;
        e = model(c, a, ids);
        @(negedge clk); frame_n = 0; irdy_n = 1; cmd = c; ad = a; idsel = ids;
        @(negedge clk); chk(tag, e);
        ad = $urandom; cmd = 4'($urandom); idsel = 1'($urandom); irdy_n = 0;
        @(negedge clk); chk("R11 data-phase change", e);
        ad = $urandom; frame_n = 1;
        @(negedge clk); chk("R10 hold", e);
        irdy_n = 1;
        @(negedge clk); chk("R10 clear", '0);
    endtask

    function automatic logic [3:0] pick_cmd();
        logic [3:0] l [6] = '{4'b1010, 4'b1011, 4'b0010, 4'b0011, 4'b0110, 4'b0111};
        if ($urandom % 5 == 0) return 4'($urandom);
        return l[$urandom % 6];
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        io_b[0] = 24'h00_1234; io_b[1] = 24'h00_5678;
        mem_b[0] = 24'hA0_0000; mem_b[1] = 24'hB0_0000;
        io_en = 2'b11; mem_en = 2'b11;
        repeat (3) @(negedge clk);
        chk("R1 in reset", '0);
        rst_n = 1;
        @(negedge clk); chk("R1 after reset", '0);

        txn(4'b1010, 32'h0000_0044, 1, "R2 cfg read fn A");
        txn(4'b1011, 32'h0000_01FC, 1, "R2 R8 cfg write fn B");
        txn(4'b1010, 32'h0000_0010, 0, "R3 no idsel");
        txn(4'b1011, 32'h0000_0510, 1, "R3 fn 5");
        txn(4'b1010, 32'h0000_0710, 1, "R3 fn 7");
        txn(4'b0010, 32'h0012_3408, 1, "R4 io read fn A");
        txn(4'b0011, 32'h0056_7801, 0, "R4 R8 io write fn B");
        txn(4'b0110, 32'hA000_0020, 0, "R5 mem read fn A");
        txn(4'b0111, 32'hB000_00FF, 0, "R5 R8 mem write fn B");
        txn(4'b1110, 32'hA000_0020, 1, "R7 unlisted cmd");
        txn(4'b0000, 32'h0012_3400, 1, "R7 unlisted cmd");
        io_en = 2'b01;
        txn(4'b0011, 32'h0056_7801, 0, "R6 io disabled fn B");
        mem_en = 2'b10;
        txn(4'b0110, 32'hA000_0020, 0, "R6 mem disabled fn A");
        io_en = 2'b11; mem_en = 2'b11;
        io_b[1] = io_b[0]; mem_b[1] = mem_b[0];
        txn(4'b0010, 32'h0012_3433, 0, "R9 io overlap");
        txn(4'b0111, 32'hA000_0077, 0, "R9 mem overlap");
        mem_en = 2'b10;
        txn(4'b0111, 32'hA000_0077, 0, "R9 R6 only fn B left");

        for (int n = 0; n < 300; n++) begin
            logic [3:0] c;
            logic [31:0] a;
            string tag;
            if (n % 40 == 0) begin
                for (int f = 0; f < 2; f++) begin
                    io_b[f] = 24'($urandom); mem_b[f] = 24'($urandom);
                end
                if ($urandom % 3 == 0) io_b[1] = io_b[0];
                if ($urandom % 3 == 0) mem_b[1] = mem_b[0];
                io_en = 2'($urandom | $urandom); mem_en = 2'($urandom | $urandom);
            end
            c = pick_cmd();
            a = $urandom;
            case ($urandom % 5)
                0: a[31:8] = io_b[$urandom % 2];
                1: a[31:8] = mem_b[$urandom % 2];
                2: a[10:8] = ($urandom % 3 == 0) ? 3'($urandom) : {2'b00, 1'($urandom)};
                default: ;
            endcase
            case (c)
                4'b1010, 4'b1011: tag = "R2 R3 random cfg";
                4'b0010, 4'b0011: tag = "R4 R8 random io";
                4'b0110, 4'b0111: tag = "R5 R9 random mem";
                default:          tag = "R7 random cmd";
            endcase
            txn(c, a, 1'($urandom), tag);
        end
        summary();
    end

endmodule